// File: doc/BRIEF.md
# Tagged Serial Receiver

This block takes an asynchronous serial input and turns each character into a 12-bit entry. The entry holds the data byte and four error flags: framing, parity, break and overrun. It reads the line using a single-cycle enable pulse at sixteen times the bit rate. Line settings select the word length, whether a parity bit is present, and the parity rule (even, odd or fixed). The receiver latches these settings at each start bit.

Entries go into a receive buffer. With buffering on, the buffer is `DEPTH` entries deep. With buffering off, it acts as one holding register. The consumer pulls entries with a read strobe, and each entry comes back one cycle later.

A separate 4-bit status register mirrors the error flags of the last entry read. Its overrun bit is the exception: it is set at the moment a character is lost. Writing to the status register clears all four bits.

Top module: `serial_rx_tagged`

## Requirements
- R1: A delivered entry has the data in bits 7:0, framing error in bit 8, parity error in bit 9, break in bit 10 and overrun in bit 11. `rd_data` is valid in the cycle after an accepted `rd_en`, marked by `rd_valid`.
- R2: `rx_status` holds framing in bit 0, parity in bit 1, break in bit 2 and overrun in bit 3. It is 0 after reset. Bits 2:0 load that entry's bits 10:8 in the cycle after `rd_valid`, and change at no other time except on a clear.
- R3: When a character completes while the buffer is full, the character is dropped. Bit 11 of the newest stored entry is set, and `rx_status[3]` sets at once. Only `stat_clr` lowers `rx_status[3]`.
- R4: A `stat_clr` pulse clears all four status bits.
- R5: After a falling edge seen on a tick, a start bit is accepted only if the line is still low on the 8th following tick. Each later bit is then sampled 16 ticks after the previous sample. A shorter low pulse produces no entry.
- R6: With `par_en`=1 a parity bit follows the data. With `par_stick`=0 the expected bit makes the number of ones even (`par_even`=1) or odd (`par_even`=0). With `par_stick`=1 the expected bit is the inverse of `par_even`. A mismatch sets bit 9. With `par_en`=0 no parity bit is read and bit 9 stays 0.
- R7: `word_len` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, sent LSB first. The data is right-aligned and the unused upper bits are 0.
- R8: Only the first stop bit is checked. If it is low, bit 8 is set. A start bit directly after a single stop bit begins a new character.
- R9: A frame in which every sampled bit is low stores exactly one entry: data 0, bits 10 and 8 set, bit 9 clear. No further entry is stored until the line has returned high.
- R10: After reset `rx_empty`=1 and `rx_full`=0. `rx_full` is set when `DEPTH` entries are held with `fifo_en`=1, or one entry with `fifo_en`=0. The two flags are never both 1.
- R11: With `rx_en`=0 no new character is started. A character already in progress when `rx_en` falls is finished and stored.
- R12: A read while the buffer is empty gives no `rd_valid` and leaves the buffer and the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial input, idle high |
| rx_en | input | 1 | Allows new characters to start |
| fifo_en | input | 1 | 1 = buffer of DEPTH entries, 0 = single holding register |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity select |
| rd_en | input | 1 | Read one entry |
| stat_clr | input | 1 | Write strobe that clears the status register |
| rd_valid | output | 1 | rd_data holds a fresh entry |
| rd_data | output | 12 | Entry: flags in 11:8, data in 7:0 |
| rx_status | output | 4 | Status register |
| rx_empty | output | 1 | Buffer empty |
| rx_full | output | 1 | Buffer full |

## Verification
The assertions assume the following about the inputs:
- `baud_tick` is a single-cycle pulse.
- The line settings stay stable during a character.
- `DEPTH` is a power of two no smaller than 2.
- A status clear and a load never land in the same cycle.

The stimulus respects these limits. It changes configuration only while the line is idle between frames. It issues reads and clears only when no character is completing. It spaces ticks four clocks apart and drives each bit for 16 ticks with unaligned edges, so mid-bit sampling sees a settled level.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;
  typedef struct packed {
    logic       ovr;
    logic       brk;
    logic       par;
    logic       frm;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_HOLD
  } rx_state_e;
endpackage

// File: rtl/srx_deframer.sv
`timescale 1ns/1ps
module srx_deframer
  import srx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        rxd,
  input  logic        rx_en,
  input  logic [1:0]  wlen,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  output logic        push,
  output logic [10:0] push_word
);
  localparam int CW   = $clog2(OVS);
  localparam int HALF = OVS / 2;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     state;
  logic [CW-1:0] tcnt;
  logic [2:0]    bidx, nb_q;
  logic [7:0]    dat;
  logic          pen_q, even_q, stick_q, allz, perr;
  logic          exp_par, at_mid;

  assign rx_s   = sync_q[1];
  assign at_mid = tick && (tcnt == CW'(OVS - 1));

  // expected parity bit, from the settings latched at the start bit
  always_comb begin
    if (stick_q) exp_par = ~even_q;
    else         exp_par = even_q ? (^dat) : ~(^dat);
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      nb_q      <= '0;
      dat       <= '0;
      pen_q     <= 1'b0;
      even_q    <= 1'b0;
      stick_q   <= 1'b0;
      allz      <= 1'b1;
      perr      <= 1'b0;
      push      <= 1'b0;
      push_word <= '0;
    end else begin
      push <= 1'b0;
      case (state)
        S_IDLE: begin
          if (tick && rx_en && !rx_s) begin
            state   <= S_START;
            tcnt    <= '0;
            nb_q    <= 3'd4 + {1'b0, wlen};
            pen_q   <= par_en;
            even_q  <= par_even;
            stick_q <= par_stick;
            dat     <= '0;
            allz    <= 1'b1;
            perr    <= 1'b0;
          end
        end
        S_START: begin
          if (tick) begin
            if (tcnt == CW'(HALF - 1)) begin
              tcnt <= '0;
              bidx <= '0;
              state <= rx_s ? S_IDLE : S_DATA;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        S_DATA: begin
          if (at_mid) begin
            tcnt      <= '0;
            dat[bidx] <= rx_s;
            if (rx_s) allz <= 1'b0;
            if (bidx == nb_q) state <= pen_q ? S_PAR : S_STOP;
            else              bidx  <= bidx + 1'b1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_PAR: begin
          if (at_mid) begin
            tcnt  <= '0;
            perr  <= (rx_s != exp_par);
            if (rx_s) allz <= 1'b0;
            state <= S_STOP;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_STOP: begin
          if (at_mid) begin
            tcnt <= '0;
            push <= 1'b1;
            if (allz && !rx_s) begin
              push_word <= {1'b1, 1'b0, 1'b1, 8'h00};
              state     <= S_HOLD;
            end else begin
              push_word <= {1'b0, pen_q & perr, ~rx_s, dat};
              state     <= S_IDLE;
            end
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_HOLD: begin
          if (rx_s) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/srx_buffer.sv
`timescale 1ns/1ps
module srx_buffer
  import srx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fifo_en,
  input  logic        push,
  input  logic [10:0] push_word,
  input  logic        rd_en,
  output logic        rd_valid,
  output rx_entry_t   rd_word,
  output logic        empty,
  output logic        full,
  output logic        ovr_evt
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [10:0]      mem [DEPTH];
  logic [DEPTH-1:0] ovr_bits;
  logic [AW-1:0]    wptr, rptr, last;
  logic [CNTW-1:0]  cnt, cnt_nxt, cap;
  logic             wr_ok, rd_ok, full_now, empty_now;
  logic [10:0]      rd_lo;
  logic             rd_hi;

  assign cap       = fifo_en ? CNTW'(DEPTH) : CNTW'(1);
  assign full_now  = (cnt >= cap);
  assign empty_now = (cnt == '0);
  assign wr_ok     = push && !full_now;
  assign ovr_evt   = push && full_now;
  assign rd_ok     = rd_en && !empty_now;
  assign last      = wptr - 1'b1;
  assign cnt_nxt   = cnt + CNTW'(wr_ok) - CNTW'(rd_ok);
  assign rd_word   = rx_entry_t'({rd_hi, rd_lo});

  // data store without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= push_word;
    if (rd_ok) rd_lo <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      cnt      <= '0;
      ovr_bits <= '0;
      rd_hi    <= 1'b0;
      rd_valid <= 1'b0;
      empty    <= 1'b1;
      full     <= 1'b0;
    end else begin
      if (wr_ok) begin
        wptr           <= wptr + 1'b1;
        ovr_bits[wptr] <= 1'b0;
      end
      if (ovr_evt) ovr_bits[last] <= 1'b1;
      if (rd_ok) begin
        rptr  <= rptr + 1'b1;
        rd_hi <= ovr_bits[rptr] | (ovr_evt && (last == rptr));
      end
      rd_valid <= rd_ok;
      cnt      <= cnt_nxt;
      empty    <= (cnt_nxt == '0);
      full     <= (cnt_nxt >= cap);
    end
  end
endmodule

// File: rtl/srx_status.sv
`timescale 1ns/1ps
module srx_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [2:0] flags,
  input  logic       ovr_evt,
  input  logic       clr,
  output logic [3:0] status
);
  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
    end else begin
      if (clr)     status       <= '0;
      if (load)    status[2:0]  <= flags;
      if (ovr_evt) status[3]    <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_rx_tagged.sv
`timescale 1ns/1ps
module serial_rx_tagged
  import srx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OVS   = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        baud_tick,
  input  logic        rxd,
  input  logic        rx_en,
  input  logic        fifo_en,
  input  logic [1:0]  word_len,
  input  logic        par_en,
  input  logic        par_even,
  input  logic        par_stick,
  input  logic        rd_en,
  input  logic        stat_clr,
  output logic        rd_valid,
  output logic [11:0] rd_data,
  output logic [3:0]  rx_status,
  output logic        rx_empty,
  output logic        rx_full
);
  logic        push, ovr_evt;
  logic [10:0] push_word;
  rx_entry_t   rd_word;

  srx_deframer #(.OVS(OVS)) u_defr (
    .clk(clk), .rst(rst), .tick(baud_tick), .rxd(rxd), .rx_en(rx_en),
    .wlen(word_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .push(push), .push_word(push_word)
  );

  srx_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .fifo_en(fifo_en), .push(push),
    .push_word(push_word), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_word(rd_word), .empty(rx_empty), .full(rx_full), .ovr_evt(ovr_evt)
  );

  srx_status u_stat (
    .clk(clk), .rst(rst), .load(rd_valid),
    .flags({rd_word.brk, rd_word.par, rd_word.frm}),
    .ovr_evt(ovr_evt), .clr(stat_clr), .status(rx_status)
  );

  assign rd_data = rd_word;
endmodule

// File: rtl/srx_checker.sv
`timescale 1ns/1ps
module srx_checker (
  input logic        clk,
  input logic        rst,
  input logic        rd_en,
  input logic        stat_clr,
  input logic        rd_valid,
  input logic [10:0] rd_low,
  input logic [3:0]  rx_status,
  input logic        rx_empty,
  input logic        rx_full
);
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rx_empty && rx_full));

  p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rx_empty && !rx_full && rx_status == 4'h0));

  p_empty_read_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rx_empty) |=> !rd_valid);

  p_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !rd_valid) |=> (rx_status[2:0] == 3'b000));

  p_ovr_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_status[3]) |-> $past(stat_clr));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> (rx_status[2:0] == $past(rd_low[10:8])));

  p_break_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_low[10]) |-> (rd_low[7:0] == 8'h00 && rd_low[8] && !rd_low[9]));
endmodule

bind serial_rx_tagged srx_checker u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .stat_clr(stat_clr),
  .rd_valid(rd_valid), .rd_low(rd_data[10:0]), .rx_status(rx_status),
  .rx_empty(rx_empty), .rx_full(rx_full)
);

// File: tb/serial_rx_tagged_tb.sv
`timescale 1ns/1ps
module serial_rx_tagged_tb;
  localparam int DEPTH  = 8;
  localparam int TDIV   = 4;
  localparam int BITCLK = 16 * TDIV;

  logic clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, rxd = 1'b1;
  logic rx_en = 1'b1, fifo_en = 1'b1, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic [1:0] word_len = 2'd3;
  logic rd_en = 1'b0, stat_clr = 1'b0;
  logic rd_valid, rx_empty, rx_full;
  logic [11:0] rd_data;
  logic [3:0]  rx_status;

  logic [11:0] q[$];
  logic [3:0]  mrsr = 4'h0;
  bit          live = 1'b0;
  int          total = 0, bad = 0, tdiv = 0;

  serial_rx_tagged #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd), .rx_en(rx_en),
    .fifo_en(fifo_en), .word_len(word_len), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .rd_en(rd_en),
    .stat_clr(stat_clr), .rd_valid(rd_valid), .rd_data(rd_data),
    .rx_status(rx_status), .rx_empty(rx_empty), .rx_full(rx_full)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    tdiv = (tdiv == TDIV - 1) ? 0 : tdiv + 1;
    baud_tick <= (tdiv == 0);
  end

  function automatic int cap();
    return fifo_en ? DEPTH : 1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference comparison on every clock while no event is in flight
  always begin
    @(negedge clk);
    #1;
    if (live) begin
      chk("R10 empty", 32'(rx_empty), 32'(q.size() == 0));
      chk("R10 full", 32'(rx_full), 32'(q.size() >= cap()));
      chk("R2 status", 32'(rx_status), 32'(mrsr));
    end
  end

  task automatic model_push(input logic [11:0] e);
    if (q.size() >= cap()) begin
      q[q.size() - 1][11] = 1'b1;
      mrsr[3] = 1'b1;
    end else begin
      q.push_back(e);
    end
  endtask

  task automatic hold_bits(input logic v, input int n);
    rxd = v;
    repeat (n * BITCLK) @(negedge clk);
  endtask

  // one frame: flip corrupts the parity bit, stopv is the stop level
  task automatic frame(input logic [7:0] d, input logic flip, input logic stopv,
                       input int gap, input bit stored);
    int nb;
    logic [7:0] m;
    logic ep;
    live = 1'b0;
    nb = 5 + int'(word_len);
    m  = 8'((1 << nb) - 1);
    if (par_stick) ep = ~par_even;
    else           ep = par_even ? ^(d & m) : ~^(d & m);
    hold_bits(1'b0, 1);
    for (int i = 0; i < nb; i++) hold_bits(d[i], 1);
    if (par_en) hold_bits(ep ^ flip, 1);
    hold_bits(stopv, 1);
    rxd = 1'b1;
    if (gap > 0) hold_bits(1'b1, gap);
    if (stored) model_push({2'b00, par_en & flip, ~stopv, d & m});
    live = 1'b1;
  endtask

  task automatic read_one(input string tag);
    logic [11:0] e;
    bit had;
    live  = 1'b0;
    had   = (q.size() != 0);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    if (had) begin
      e = q.pop_front();
      chk({tag, " valid"}, 32'(rd_valid), 32'd1);
      chk({tag, " data"}, 32'(rd_data), 32'(e));
    end else begin
      chk({tag, " no valid"}, 32'(rd_valid), 32'd0);
    end
    @(negedge clk);
    if (had) mrsr[2:0] = e[10:8];
    live = 1'b1;
  endtask

  task automatic clear_status();
    live = 1'b0;
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    mrsr = 4'h0;
    @(negedge clk);
    live = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R10 reset empty", 32'(rx_empty), 32'd1);
    chk("R10 reset full", 32'(rx_full), 32'd0);
    chk("R2 reset status", 32'(rx_status), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    live = 1'b1;

    // R1 / R7: eight data bits, then shorter words
    frame(8'hA5, 1'b0, 1'b1, 2, 1'b1);
    read_one("R1 byte");
    word_len = 2'd0; frame(8'h3B, 1'b0, 1'b1, 2, 1'b1); read_one("R7 five");
    word_len = 2'd1; frame(8'hFF, 1'b0, 1'b1, 2, 1'b1); read_one("R7 six");
    word_len = 2'd2; frame(8'hD5, 1'b0, 1'b1, 2, 1'b1); read_one("R7 seven");
    word_len = 2'd3;

    // R6: parity rules
    par_en = 1'b1;
    par_even = 1'b1; frame(8'h0F, 1'b0, 1'b1, 2, 1'b1); read_one("R6 even ok");
    frame(8'h0E, 1'b1, 1'b1, 2, 1'b1); read_one("R6 even bad");
    par_even = 1'b0; frame(8'h31, 1'b0, 1'b1, 2, 1'b1); read_one("R6 odd ok");
    frame(8'h31, 1'b1, 1'b1, 2, 1'b1); read_one("R6 odd bad");
    par_stick = 1'b1; frame(8'h77, 1'b0, 1'b1, 2, 1'b1); read_one("R6 stick one");
    frame(8'h77, 1'b1, 1'b1, 2, 1'b1); read_one("R6 stick one bad");
    par_even = 1'b1; frame(8'h12, 1'b0, 1'b1, 2, 1'b1); read_one("R6 stick zero");
    par_stick = 1'b0; par_en = 1'b0;

    // R4: clear after an error was loaded
    frame(8'h12, 1'b0, 1'b0, 2, 1'b1); read_one("R8 stop low");
    clear_status();
    chk("R4 cleared", 32'(rx_status), 32'd0);

    // R8: back-to-back frames with one stop bit each
    frame(8'h5A, 1'b0, 1'b1, 0, 1'b1);
    frame(8'hC3, 1'b0, 1'b1, 2, 1'b1);
    read_one("R8 first"); read_one("R8 second");

    // R5: short low pulse is no start bit
    live = 1'b0;
    rxd = 1'b0; repeat (4 * TDIV) @(negedge clk);
    hold_bits(1'b1, 3);
    live = 1'b1;
    @(negedge clk);
    chk("R5 glitch ignored", 32'(rx_empty), 32'd1);

    // R9: break, with a parity bit in the frame
    par_en = 1'b1;
    live = 1'b0;
    hold_bits(1'b0, 20);
    hold_bits(1'b1, 2);
    model_push(12'h500);
    live = 1'b1;
    read_one("R9 break");
    read_one("R12 empty read");
    chk("R9 single entry", 32'(rx_empty), 32'd1);
    par_en = 1'b0;

    // R11: disabled receiver, then disable mid-character
    rx_en = 1'b0;
    frame(8'h66, 1'b0, 1'b1, 2, 1'b0);
    chk("R11 no start", 32'(rx_empty), 32'd1);
    rx_en = 1'b1;
    fork
      frame(8'h99, 1'b0, 1'b1, 2, 1'b1);
      begin repeat (3 * BITCLK) @(negedge clk); rx_en = 1'b0; end
    join
    read_one("R11 finished char");
    rx_en = 1'b1;

    // R3 / R10: fill the buffer and overflow it
    for (int i = 0; i <= DEPTH; i++) frame(8'(8'h20 + i), 1'b0, 1'b1, 1, 1'b1);
    chk("R10 full at depth", 32'(rx_full), 32'd1);
    chk("R3 overrun status", 32'(rx_status[3]), 32'd1);
    for (int i = 0; i < DEPTH; i++) read_one("R3 drain");
    chk("R3 overrun held after reads", 32'(rx_status[3]), 32'd1);
    clear_status();
    chk("R4 overrun cleared", 32'(rx_status), 32'd0);

    // R10: single holding register
    fifo_en = 1'b0;
    frame(8'h41, 1'b0, 1'b1, 1, 1'b1);
    chk("R10 holding full", 32'(rx_full), 32'd1);
    frame(8'h42, 1'b0, 1'b1, 1, 1'b1);
    read_one("R3 holding overrun");
    chk("R3 status overrun", 32'(rx_status[3]), 32'd1);
    read_one("R12 empty read 2");
    clear_status();
    fifo_en = 1'b1;

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule